// File: doc/BRIEF.md
# PS/2 Device-to-Host Receiver with Edge-Interval Screening

This block takes the clock and data lines of a PS/2 port and rebuilds the bytes that the device sends to the host. Both lines first pass through a synchronizer. The block then acts on each falling edge of the synchronized clock. A free-running microsecond timebase measures the time since the last edge that was accepted, and it also measures the time since the host last finished a transmission. Each edge is screened against a tolerance window before its data sample is used. An edge that comes too soon is treated as a glitch and dropped. An edge that comes too late in the middle of a frame ends the frame as a timeout.

A frame has 11 bits: a start bit, eight data bits sent least significant bit first, an odd parity bit and a stop bit. A good frame ends in a one-cycle `byte_valid` strobe, and `rx_byte` carries the byte during that strobe. Any framing or timing fault clears the receiver and produces a one-cycle `resend_req`. The host transmit path takes that request and sends the resend command 0xFE.

The output is valid-only and has no ready input. The device cannot be stalled once a frame is on the wire, so a consumer must take `rx_byte` in the cycle that `byte_valid` is high. `rx_byte` keeps its value until the next good frame.

Top module: `ps2_edge_rx`

## Requirements
- R1: After reset, `byte_valid` and `resend_req` are low and `rx_byte` is zero.
- R2: A frame of start bit 0, eight data bits sent LSB first, a parity bit that makes the nine bits odd, and stop bit 1 produces exactly one `byte_valid` pulse, one clock wide, with `rx_byte` equal to the data.
- R3: A falling edge less than MIN_GAP_US (default 40) microseconds after the last accepted edge is dropped. It does not sample data, does not advance the bit position and does not restart the interval measurement.
- R4: A falling edge more than MAX_GAP_US (default 120) microseconds after the last accepted edge, while a frame is partly received, aborts the frame and pulses `resend_req` for one clock.
- R5: When no frame is in progress, an edge is accepted after any idle time, however long.
- R6: A falling edge less than MIN_GAP_US microseconds after a `tx_done` pulse is dropped without effect.
- R7: A start bit sampled as 1 clears the receiver and pulses `resend_req`.
- R8: A parity bit that leaves the nine bits with an even number of ones clears the receiver and pulses `resend_req`, and no `byte_valid` is given for that frame.
- R9: A stop bit sampled as 0 clears the receiver and pulses `resend_req`, and no `byte_valid` is given.
- R10: After any error, the next frame is received correctly from its start bit.
- R11: `byte_valid` or `resend_req` rises exactly three clocks after the clock edge at which the pin falls: two clocks in the synchronizer and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_in | input | 1 | PS/2 clock line as seen at the pad, asynchronous |
| ps2_data_in | input | 1 | PS/2 data line as seen at the pad, asynchronous |
| tx_done | input | 1 | One-cycle pulse when the host transmit path finishes a frame |
| rx_byte | output | DATA_BITS | Last byte received correctly |
| byte_valid | output | 1 | One-cycle strobe: `rx_byte` holds a new byte |
| resend_req | output | 1 | One-cycle request that the host send the resend command 0xFE |

## Verification
The bench inserts a glitch edge with inverted data in the middle of a frame. A design that accepted that edge would shift in a wrong bit and report a corrupted byte. A late edge in mid-frame must raise a resend. A long idle before a start bit must not raise one; a design that did not check for an empty frame would abort every first edge. An edge that follows `tx_done` closely carries a start value of 1. If it were accepted, it would raise a bad-start resend that the bench does not expect. Errors in the start, parity and stop bits are each followed by a clean frame, which shows that an error left no stale count or shift state behind.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

  // What the edge screen decides for one falling edge
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_TAKE  = 2'd1,
    EV_ABORT = 2'd2
  } edge_ev_t;

  // Width of a counter that has n distinct states, never below one bit
  function automatic int unsigned width_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ps2_sync.sv
module ps2_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[g] <= '1;
          else        stage_q[g] <= din;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[g] <= '1;
          else        stage_q[g] <= stage_q[g-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/ps2_us_timer.sv
module ps2_us_timer
  import ps2rx_pkg::*;
#(
  parameter int CLKS_PER_US = 250,
  parameter int MIN_GAP_US  = 40,
  parameter int MAX_GAP_US  = 120,
  parameter int GAP_W       = 7,
  parameter int TX_W        = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             tx_done,
  output logic [GAP_W-1:0] gap_us,
  output logic [TX_W-1:0]  tx_us
);

  localparam int               PRE_W    = width_of(CLKS_PER_US);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);
  localparam logic [GAP_W-1:0] GAP_SAT  = GAP_W'(MAX_GAP_US + 1);
  localparam logic [TX_W-1:0]  TX_SAT   = TX_W'(MIN_GAP_US);

  logic [PRE_W-1:0] pre_q;
  logic             us_tick;

  assign us_tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pre_q <= '0;
    else if (us_tick) pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;

  // Microseconds since the last accepted edge, held at one past the limit
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              gap_us <= GAP_SAT;
    else if (take)                           gap_us <= '0;
    else if (us_tick && gap_us != GAP_SAT)   gap_us <= gap_us + 1'b1;

  // Microseconds since the host finished sending, held at the minimum gap
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              tx_us <= TX_SAT;
    else if (tx_done)                        tx_us <= '0;
    else if (us_tick && tx_us != TX_SAT)     tx_us <= tx_us + 1'b1;

endmodule

// File: rtl/ps2_edge_gate.sv
module ps2_edge_gate
  import ps2rx_pkg::*;
#(
  parameter int MIN_GAP_US = 40,
  parameter int MAX_GAP_US = 120,
  parameter int GAP_W      = 7,
  parameter int TX_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_s,
  input  logic [GAP_W-1:0] gap_us,
  input  logic [TX_W-1:0]  tx_us,
  input  logic             frame_busy,
  output logic             fall_evt,
  output edge_ev_t         ev
);

  logic clk_prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) clk_prev_q <= 1'b1;
    else        clk_prev_q <= clk_s;

  assign fall_evt = clk_prev_q & ~clk_s;

  // Order of tests: host quiet time, mid-frame timeout, glitch, accept
  always_comb begin
    ev = EV_NONE;
    if (fall_evt) begin
      if (tx_us < TX_W'(MIN_GAP_US))                        ev = EV_NONE;
      else if (gap_us > GAP_W'(MAX_GAP_US) && frame_busy)   ev = EV_ABORT;
      else if (gap_us < GAP_W'(MIN_GAP_US))                 ev = EV_NONE;
      else                                                  ev = EV_TAKE;
    end
  end

endmodule

// File: rtl/ps2_frame_shift.sv
module ps2_frame_shift
  import ps2rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int CNT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  edge_ev_t             ev,
  input  logic                 din,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 byte_valid,
  output logic                 resend_req,
  output logic [CNT_W-1:0]     bit_cnt
);

  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_BITS);
  localparam logic [CNT_W-1:0] PAR_IDX   = CNT_W'(DATA_BITS + 1);
  localparam logic [CNT_W-1:0] STOP_IDX  = CNT_W'(DATA_BITS + 2);

  logic [DATA_BITS-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      sh_q       <= '0;
      rx_byte    <= '0;
      byte_valid <= 1'b0;
      resend_req <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      resend_req <= 1'b0;
      if (ev == EV_ABORT) begin
        bit_cnt    <= '0;
        sh_q       <= '0;
        resend_req <= 1'b1;
      end else if (ev == EV_TAKE) begin
        if (bit_cnt == '0) begin
          if (din) begin
            resend_req <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end else if (bit_cnt <= LAST_DATA) begin
          sh_q    <= {din, sh_q[DATA_BITS-1:1]};
          bit_cnt <= bit_cnt + 1'b1;
        end else if (bit_cnt == PAR_IDX && (^{sh_q, din})) begin
          bit_cnt <= bit_cnt + 1'b1;
        end else if (bit_cnt == STOP_IDX && din) begin
          rx_byte    <= sh_q;
          byte_valid <= 1'b1;
          bit_cnt    <= '0;
          sh_q       <= '0;
        end else begin
          bit_cnt    <= '0;
          sh_q       <= '0;
          resend_req <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ps2_edge_rx.sv
module ps2_edge_rx
  import ps2rx_pkg::*;
#(
  parameter int CLKS_PER_US = 250,
  parameter int MIN_GAP_US  = 40,
  parameter int MAX_GAP_US  = 120,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ps2_clk_in,
  input  logic                 ps2_data_in,
  input  logic                 tx_done,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 byte_valid,
  output logic                 resend_req
);

  localparam int GAP_W = width_of(MAX_GAP_US + 2);
  localparam int TX_W  = width_of(MIN_GAP_US + 1);
  localparam int CNT_W = width_of(DATA_BITS + 3);

  logic             clk_s, data_s;
  logic             fall_evt;
  edge_ev_t         ev;
  logic [GAP_W-1:0] gap_us;
  logic [TX_W-1:0]  tx_us;
  logic [CNT_W-1:0] bit_cnt;

  ps2_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ps2_data_in, ps2_clk_in}),
    .dout ({data_s, clk_s})
  );

  ps2_us_timer #(
    .CLKS_PER_US(CLKS_PER_US), .MIN_GAP_US(MIN_GAP_US),
    .MAX_GAP_US(MAX_GAP_US), .GAP_W(GAP_W), .TX_W(TX_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (ev == EV_TAKE),
    .tx_done(tx_done),
    .gap_us (gap_us),
    .tx_us  (tx_us)
  );

  ps2_edge_gate #(
    .MIN_GAP_US(MIN_GAP_US), .MAX_GAP_US(MAX_GAP_US),
    .GAP_W(GAP_W), .TX_W(TX_W)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_s     (clk_s),
    .gap_us    (gap_us),
    .tx_us     (tx_us),
    .frame_busy(bit_cnt != '0),
    .fall_evt  (fall_evt),
    .ev        (ev)
  );

  ps2_frame_shift #(.DATA_BITS(DATA_BITS), .CNT_W(CNT_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .din       (data_s),
    .rx_byte   (rx_byte),
    .byte_valid(byte_valid),
    .resend_req(resend_req),
    .bit_cnt   (bit_cnt)
  );

endmodule

// File: rtl/ps2_edge_rx_chk.sv
module ps2_edge_rx_chk #(
  parameter int MIN_GAP_US = 40,
  parameter int MAX_GAP_US = 120,
  parameter int GAP_W      = 7,
  parameter int TX_W       = 6,
  parameter int CNT_W      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fall_evt,
  input logic [GAP_W-1:0] gap_us,
  input logic [TX_W-1:0]  tx_us,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             byte_valid,
  input logic             resend_req
);

  logic tx_quiet, too_soon, too_late;
  assign tx_quiet = tx_us < TX_W'(MIN_GAP_US);
  assign too_soon = gap_us < GAP_W'(MIN_GAP_US);
  assign too_late = gap_us > GAP_W'(MAX_GAP_US);

  AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid); // R2

  AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && !tx_quiet && too_soon) |=> ($stable(bit_cnt) && !byte_valid && !resend_req)); // R3

  AST_MIDFRAME_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && !tx_quiet && too_late && bit_cnt != '0) |=> (resend_req && bit_cnt == '0)); // R4

  AST_RESEND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resend_req |=> !resend_req); // R4

  AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && tx_quiet) |=> ($stable(bit_cnt) && !byte_valid && !resend_req)); // R6

  AST_OUT_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid || resend_req) |-> $past(fall_evt)); // R11

endmodule

bind ps2_edge_rx ps2_edge_rx_chk #(
  .MIN_GAP_US(MIN_GAP_US), .MAX_GAP_US(MAX_GAP_US),
  .GAP_W(GAP_W), .TX_W(TX_W), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fall_evt  (fall_evt),
  .gap_us    (gap_us),
  .tx_us     (tx_us),
  .bit_cnt   (bit_cnt),
  .byte_valid(byte_valid),
  .resend_req(resend_req)
);

// File: tb/ps2_edge_rx_test.sv
module ps2_edge_rx_test;

  localparam int N    = 4;    // clocks per microsecond in this bench
  localparam int MINU = 40;
  localparam int MAXU = 120;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pclk = 1'b1;
  logic       pdat = 1'b1;
  logic       txd = 1'b0;
  logic [7:0] rx_byte;
  logic       byte_valid, resend_req;

  always #2 clk = ~clk;

  ps2_edge_rx #(.CLKS_PER_US(N), .MIN_GAP_US(MINU), .MAX_GAP_US(MAXU)) uut (
    .clk(clk), .rst_n(rst_n), .ps2_clk_in(pclk), .ps2_data_in(pdat),
    .tx_done(txd), .rx_byte(rx_byte), .byte_valid(byte_valid),
    .resend_req(resend_req)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  // Reference model state
  int         m_cnt = 0, m_last = -1, m_tx = -1000000;
  logic [7:0] m_sh = 8'h00, m_byte = 8'h00, last_byte = 8'h00;
  int         bv_due = -1, rs_due = -1, nbv = 0, nrs = 0;

  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model of one pin-level falling edge, decided from elapsed microseconds
  function automatic void model_fall(input logic d);
    int gap;
    bit err;
    err = 1'b0;
    if ((cyc - m_tx) / N < MINU) return;                   // R6
    gap = (m_last < 0) ? 1000000 : (cyc - m_last) / N;
    if (gap > MAXU && m_cnt != 0) err = 1'b1;              // R4
    else if (gap < MINU) return;                           // R3
    else begin
      m_last = cyc;
      if (m_cnt == 0) begin
        if (d) err = 1'b1; else m_cnt = 1;
      end else if (m_cnt <= 8) begin
        m_sh = {d, m_sh[7:1]};
        m_cnt++;
      end else if (m_cnt == 9) begin
        if (^{m_sh, d}) m_cnt = 10; else err = 1'b1;
      end else begin
        if (d) begin
          m_byte = m_sh; bv_due = cyc + 3; m_cnt = 0; m_sh = 8'h00;
        end else err = 1'b1;
      end
    end
    if (err) begin
      m_cnt = 0; m_sh = 8'h00; rs_due = cyc + 3;
    end
  endfunction

  // Compare outputs against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R11 byte_valid cycle", int'(byte_valid), int'(cyc == bv_due));
      chk("R4 R11 resend_req cycle", int'(resend_req), int'(cyc == rs_due));
      if (cyc == bv_due) chk("R2 rx_byte value", int'(rx_byte), int'(m_byte));
      if (byte_valid) begin nbv++; last_byte = rx_byte; end
      if (resend_req) nrs++;
    end
  end

  task automatic fall_after(input logic d, input int gap_us);
    int half;
    half = gap_us * N / 2;
    repeat (half) @(negedge clk);
    pclk = 1'b1;
    pdat = d;
    repeat (gap_us * N - half) @(negedge clk);
    pclk = 1'b0;
    model_fall(d);
  endtask

  // mode: 0 clean, 1 glitch before bit 4, 2 late bit 5, 3 bad start,
  //       4 bad parity, 5 bad stop
  task automatic send_frame(input logic [7:0] b, input int gap, input int mode,
                            input int first_gap);
    logic [10:0] f;
    f = {1'b1, ~^b, b, 1'b0};
    if (mode == 3) f[0]  = 1'b1;
    if (mode == 4) f[9]  = ~f[9];
    if (mode == 5) f[10] = 1'b0;
    for (int i = 0; i < 11; i++) begin
      if (mode == 1 && i == 4) begin
        fall_after(~f[i], 30);
        fall_after(f[i], gap - 30);
      end else begin
        fall_after(f[i], (i == 0) ? first_gap : ((mode == 2 && i == 5) ? 130 : gap));
      end
      if ((mode == 2 && i == 5) || (mode == 3 && i == 0) || (mode == 4 && i == 9)) break;
    end
    repeat (40 * N) @(negedge clk);
    pclk = 1'b1;
    pdat = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic run(input string req, input logic [7:0] b, input int gap,
                     input int mode, input int first_gap,
                     input int exp_bv, input int exp_rs);
    int bv0, rs0;
    bv0 = nbv;
    rs0 = nrs;
    send_frame(b, gap, mode, first_gap);
    chk({req, " byte count"}, nbv - bv0, exp_bv);
    chk({req, " resend count"}, nrs - rs0, exp_rs);
    if (exp_bv != 0) chk({req, " data"}, int'(last_byte), int'(b));
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 byte_valid after reset", int'(byte_valid), 0);
    chk("R1 resend_req after reset", int'(resend_req), 0);
    chk("R1 rx_byte after reset", int'(rx_byte), 0);

    run("R5 first edge after long idle", 8'hA5, 80, 0, 300, 1, 0);
    run("R2 all zeros at 65us", 8'h00, 65, 0, 100, 1, 0);
    run("R2 all ones at 110us", 8'hFF, 110, 0, 100, 1, 0);
    run("R3 glitch edge dropped", 8'h3C, 80, 1, 100, 1, 0);
    run("R4 late edge mid-frame", 8'h5A, 80, 2, 100, 0, 1);
    run("R10 clean frame after timeout", 8'hC3, 80, 0, 150, 1, 0);
    run("R7 start bit high", 8'h12, 80, 3, 100, 0, 1);
    run("R8 parity wrong", 8'h96, 80, 4, 100, 0, 1);
    run("R9 stop bit low", 8'h69, 80, 5, 100, 0, 1);
    run("R10 clean frame after stop error", 8'h81, 90, 0, 100, 1, 0);

    begin : tx_case
      int bv0, rs0;
      bv0 = nbv;
      rs0 = nrs;
      @(negedge clk);
      txd = 1'b1;
      m_tx = cyc;
      @(negedge clk);
      txd = 1'b0;
      fall_after(1'b1, 20);   // would be a bad start if taken
      send_frame(8'hE7, 80, 0, 60);
      chk("R6 edge after tx_done resend count", nrs - rs0, 0);
      chk("R6 edge after tx_done byte count", nbv - bv0, 1);
      chk("R6 edge after tx_done data", int'(last_byte), 32'hE7);
    end

    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      finish_run();
    end
  end

endmodule